// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Clock Gating

This controller tracks which power state the processor is in and turns that state into enables for three clock domains: core, system and bus. While awake, the processor runs either at full regulator output or in a very-low-power run state, chosen by a level input. A single-cycle sleep request stands in for the processor's wait-for-interrupt instruction. A deep-sleep qualifier chooses between a wait state and a stop state. When stop is chosen, a two-bit configuration field decides between a full stop and a partial stop that keeps the bus clock running.

Any bit of the pending-interrupt vector wakes the block from every sleep state. The block then goes back to the run state that was active when the request was taken. It also drives a low-power request to the regulator, enables the asynchronous wake controller while normal interrupt handling is switched off, and reports the current state as a three-bit code.

Top module: `lp_mode_seq`

## Requirements
- R1: A sleep request with the deep qualifier low enters wait. The wait state depends on the current run state: RUN goes to WAIT and VLPR goes to VLPW. In both wait states the core enable is low and the system and bus enables stay high.
- R2: In any sleep state, if one or more pending-interrupt bits are set at a clock edge, the block returns at that edge to the run state it left. From the next cycle all three clock enables are high again.
- R3: A sleep request with the deep qualifier high and a configuration field of 00, 01 or 11 enters STOP. In STOP all three clock enables are low and the wake-controller enable is high.
- R4: A sleep request with the deep qualifier high and a configuration field of 10 enters PSTOP from either run state. In PSTOP the core and system enables are low, the bus enable stays high and the wake-controller enable is high.
- R5: The regulator low-power request is high in VLPR and VLPW. It is also high in STOP or PSTOP when those were entered from VLPR. It is low in every other case.
- R6: In a run state with no sleep request, the next state is VLPR when the run-select input is 1 and RUN when it is 0. In a sleep state the run-select input is ignored.
- R7: A sleep request is ignored while the block is asleep. A sleep request taken in a run state uses the run state held in that cycle, not the run-select value of the same cycle. A sleep request is honoured even when an interrupt is already pending; the wake then follows in the next cycle.
- R8: An active-low asynchronous reset forces RUN at once from any state. During and after reset all clock enables are high, the regulator request is low and the wake-controller enable is low.
- R9: The mode code is 0 RUN, 1 VLPR, 2 WAIT, 3 VLPW, 4 STOP, 5 PSTOP. The wake-controller enable is high only in STOP and PSTOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vlp_sel_i | input | 1 | Run-state select: 1 very-low-power run, 0 normal run |
| slp_req_i | input | 1 | Single-cycle sleep request |
| deep_i | input | 1 | Deep-sleep qualifier: 1 stop, 0 wait |
| pstop_cfg_i | input | 2 | Stop variant: 10 partial stop, any other value full stop |
| irq_pend_i | input | NUM_IRQ | Pending-interrupt vector |
| core_clk_en_o | output | 1 | Core clock enable |
| sys_clk_en_o | output | 1 | System clock enable |
| bus_clk_en_o | output | 1 | Bus clock enable |
| reg_lp_req_o | output | 1 | Regulator low-power request |
| wake_ctl_en_o | output | 1 | Asynchronous wake-controller enable |
| mode_o | output | 3 | Current state code |

## Verification
Sleep requests are issued from both run states, with the deep qualifier low and high and with all four configuration codes. This shows that the wait target follows the run state and that only code 10 keeps the bus clock alive. Wakes use different single interrupt bits and come back to both run states, which shows that the return state is taken from the saved state and not from the run-select input. Further patterns combine inputs in the same cycle: a request together with a change of run-select, a request with an interrupt already pending, and requests or run-select changes while asleep. These separate the precedence rules from the plain decode. A directed reset from a stop state entered out of VLPR checks that both the state and the saved return state are cleared.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [2:0] {
    MD_RUN   = 3'd0,
    MD_VLPR  = 3'd1,
    MD_WAIT  = 3'd2,
    MD_VLPW  = 3'd3,
    MD_STOP  = 3'd4,
    MD_PSTOP = 3'd5
  } lp_mode_e;

  localparam logic [1:0] PSTOP_CFG_PARTIAL = 2'b10;

  localparam int DOM_CORE = 0;
  localparam int DOM_SYS  = 1;
  localparam int DOM_BUS  = 2;
  localparam int NUM_DOM  = 3;

  function automatic logic is_asleep(lp_mode_e m);
    return (m == MD_WAIT) || (m == MD_VLPW) || (m == MD_STOP) || (m == MD_PSTOP);
  endfunction

  function automatic logic is_awake(lp_mode_e m);
    return (m == MD_RUN) || (m == MD_VLPR);
  endfunction
endpackage

// File: rtl/lp_wake_det.sv
module lp_wake_det
  import lp_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  input  lp_mode_e           mode_i,
  output logic               wake_o
);
  logic any_irq;

  assign any_irq = |irq_pend_i;
  assign wake_o  = any_irq && is_asleep(mode_i);
endmodule

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
  import lp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vlp_sel_i,
  input  logic       slp_req_i,
  input  logic       deep_i,
  input  logic [1:0] pstop_cfg_i,
  input  logic       wake_i,
  output lp_mode_e   mode_o,
  output logic       ret_vlp_o
);
  lp_mode_e mode_q, mode_d;
  logic     ret_vlp_q, ret_vlp_d;

  always_comb begin
    mode_d    = mode_q;
    ret_vlp_d = ret_vlp_q;
    unique case (mode_q)
      MD_RUN, MD_VLPR: begin
        if (slp_req_i) begin
          ret_vlp_d = (mode_q == MD_VLPR);
          if (!deep_i)
            mode_d = (mode_q == MD_VLPR) ? MD_VLPW : MD_WAIT;
          else if (pstop_cfg_i == PSTOP_CFG_PARTIAL)
            mode_d = MD_PSTOP;
          else
            mode_d = MD_STOP;
        end else begin
          mode_d = vlp_sel_i ? MD_VLPR : MD_RUN;
        end
      end
      MD_WAIT, MD_VLPW, MD_STOP, MD_PSTOP: begin
        if (wake_i) mode_d = ret_vlp_q ? MD_VLPR : MD_RUN;
      end
      default: mode_d = MD_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MD_RUN;
      ret_vlp_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      ret_vlp_q <= ret_vlp_d;
    end
  end

  assign mode_o    = mode_q;
  assign ret_vlp_o = ret_vlp_q;

  // R1
  wait_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_awake(mode_q) && slp_req_i && !deep_i) |=>
      (mode_q == ((ret_vlp_q) ? MD_VLPW : MD_WAIT)));

  // R2
  wake_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_asleep(mode_q) && wake_i) |=> is_awake(mode_q));

  // R6
  run_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_awake(mode_q) && !slp_req_i) |=>
      (mode_q == ($past(vlp_sel_i) ? MD_VLPR : MD_RUN)));

  // R7
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_asleep(mode_q) && !wake_i) |=> $stable(mode_q) && $stable(ret_vlp_q));
endmodule

// File: rtl/lp_clk_dec.sv
module lp_clk_dec
  import lp_pkg::*;
(
  input  lp_mode_e           mode_i,
  input  logic               ret_vlp_i,
  output logic [NUM_DOM-1:0] clk_en_o,
  output logic               reg_lp_o,
  output logic               wake_ctl_o
);
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    always_comb begin
      unique case (mode_i)
        MD_RUN, MD_VLPR:  clk_en_o[d] = 1'b1;
        MD_WAIT, MD_VLPW: clk_en_o[d] = (d != DOM_CORE);
        MD_PSTOP:         clk_en_o[d] = (d == DOM_BUS);
        default:          clk_en_o[d] = 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (mode_i)
      MD_VLPR, MD_VLPW:   reg_lp_o = 1'b1;
      MD_STOP, MD_PSTOP:  reg_lp_o = ret_vlp_i;
      default:            reg_lp_o = 1'b0;
    endcase
  end

  assign wake_ctl_o = (mode_i == MD_STOP) || (mode_i == MD_PSTOP);
endmodule

// File: rtl/lp_mode_seq.sv
module lp_mode_seq
  import lp_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vlp_sel_i,
  input  logic               slp_req_i,
  input  logic               deep_i,
  input  logic [1:0]         pstop_cfg_i,
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  output logic               core_clk_en_o,
  output logic               sys_clk_en_o,
  output logic               bus_clk_en_o,
  output logic               reg_lp_req_o,
  output logic               wake_ctl_en_o,
  output logic [2:0]         mode_o
);
  lp_mode_e           mode;
  logic               ret_vlp;
  logic               wake;
  logic [NUM_DOM-1:0] clk_en;

  lp_wake_det #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .irq_pend_i (irq_pend_i),
    .mode_i     (mode),
    .wake_o     (wake)
  );

  lp_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vlp_sel_i   (vlp_sel_i),
    .slp_req_i   (slp_req_i),
    .deep_i      (deep_i),
    .pstop_cfg_i (pstop_cfg_i),
    .wake_i      (wake),
    .mode_o      (mode),
    .ret_vlp_o   (ret_vlp)
  );

  lp_clk_dec u_dec (
    .mode_i     (mode),
    .ret_vlp_i  (ret_vlp),
    .clk_en_o   (clk_en),
    .reg_lp_o   (reg_lp_req_o),
    .wake_ctl_o (wake_ctl_en_o)
  );

  assign core_clk_en_o = clk_en[DOM_CORE];
  assign sys_clk_en_o  = clk_en[DOM_SYS];
  assign bus_clk_en_o  = clk_en[DOM_BUS];
  assign mode_o        = mode;

  // R4
  pstop_bus_alive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5) |-> (bus_clk_en_o && !core_clk_en_o && !sys_clk_en_o && wake_ctl_en_o));

  // R3
  bus_gate_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_clk_en_o) |-> ($past(slp_req_i) && $past(deep_i) && mode_o == 3'd4));

  // R2
  wake_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_clk_en_o && (|irq_pend_i)) |=> (core_clk_en_o && sys_clk_en_o && bus_clk_en_o));

  // R5
  reg_lp_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd0 || mode_o == 3'd2) |-> !reg_lp_req_o);
endmodule

// File: tb/lp_mode_seq_tb_top.sv
`timescale 1ns/1ps
module lp_mode_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vlp_sel = 1'b0, slp_req = 1'b0, deep = 1'b0;
  logic [1:0] cfg = 2'b00;
  logic [7:0] irq = 8'h00;
  logic       core_en, sys_en, bus_en, lp_req, wake_ctl;
  logic [2:0] mode;
  int         checks = 0;
  int         failures = 0;

  always #5 clk = ~clk;

  lp_mode_seq #(.NUM_IRQ(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .vlp_sel_i(vlp_sel), .slp_req_i(slp_req),
    .deep_i(deep), .pstop_cfg_i(cfg), .irq_pend_i(irq),
    .core_clk_en_o(core_en), .sys_clk_en_o(sys_en), .bus_clk_en_o(bus_en),
    .reg_lp_req_o(lp_req), .wake_ctl_en_o(wake_ctl), .mode_o(mode)
  );

  typedef struct packed {
    logic       vlp;
    logic       req;
    logic       dp;
    logic [1:0] cf;
    logic [7:0] ir;
    logic [2:0] md;
    logic [2:0] en;   // {core, sys, bus}
    logic       lp;
    logic       wk;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,2'b00,8'h00,3'd0,3'b111,1'b0,1'b0,4'd9}, // R9 idle RUN
    '{1'b0,1'b1,1'b0,2'b00,8'h00,3'd2,3'b011,1'b0,1'b0,4'd1}, // R1 RUN->WAIT
    '{1'b0,1'b0,1'b0,2'b00,8'h00,3'd2,3'b011,1'b0,1'b0,4'd7}, // R7 stays
    '{1'b0,1'b0,1'b0,2'b00,8'h01,3'd0,3'b111,1'b0,1'b0,4'd2}, // R2 wake
    '{1'b1,1'b0,1'b0,2'b00,8'h00,3'd1,3'b111,1'b1,1'b0,4'd6}, // R6 to VLPR
    '{1'b1,1'b1,1'b0,2'b00,8'h00,3'd3,3'b011,1'b1,1'b0,4'd1}, // R1 VLPR->VLPW
    '{1'b0,1'b0,1'b0,2'b00,8'h00,3'd3,3'b011,1'b1,1'b0,4'd6}, // R6 select ignored
    '{1'b1,1'b0,1'b0,2'b00,8'h80,3'd1,3'b111,1'b1,1'b0,4'd2}, // R2 back to VLPR
    '{1'b1,1'b1,1'b1,2'b00,8'h00,3'd4,3'b000,1'b1,1'b1,4'd3}, // R3 STOP from VLPR
    '{1'b1,1'b0,1'b0,2'b00,8'h04,3'd1,3'b111,1'b1,1'b0,4'd2}, // R2
    '{1'b0,1'b0,1'b0,2'b00,8'h00,3'd0,3'b111,1'b0,1'b0,4'd6}, // R6 to RUN
    '{1'b0,1'b1,1'b1,2'b01,8'h00,3'd4,3'b000,1'b0,1'b1,4'd3}, // R3 code 01
    '{1'b0,1'b1,1'b0,2'b00,8'h00,3'd4,3'b000,1'b0,1'b1,4'd7}, // R7 request ignored
    '{1'b0,1'b0,1'b0,2'b00,8'h10,3'd0,3'b111,1'b0,1'b0,4'd2}, // R2
    '{1'b0,1'b1,1'b1,2'b10,8'h00,3'd5,3'b001,1'b0,1'b1,4'd4}, // R4 PSTOP from RUN
    '{1'b0,1'b0,1'b0,2'b00,8'h02,3'd0,3'b111,1'b0,1'b0,4'd2}, // R2
    '{1'b1,1'b0,1'b0,2'b00,8'h00,3'd1,3'b111,1'b1,1'b0,4'd6}, // R6
    '{1'b1,1'b1,1'b1,2'b10,8'h00,3'd5,3'b001,1'b1,1'b1,4'd4}, // R4 PSTOP from VLPR
    '{1'b1,1'b0,1'b0,2'b00,8'h20,3'd1,3'b111,1'b1,1'b0,4'd2}, // R2
    '{1'b1,1'b1,1'b1,2'b11,8'h00,3'd4,3'b000,1'b1,1'b1,4'd3}, // R3 code 11
    '{1'b0,1'b0,1'b0,2'b00,8'h08,3'd1,3'b111,1'b1,1'b0,4'd2}, // R2 saved VLPR wins
    '{1'b0,1'b0,1'b0,2'b00,8'h00,3'd0,3'b111,1'b0,1'b0,4'd6}, // R6
    '{1'b0,1'b1,1'b0,2'b00,8'h40,3'd2,3'b011,1'b0,1'b0,4'd7}, // R7 request with irq
    '{1'b0,1'b0,1'b0,2'b00,8'h40,3'd0,3'b111,1'b0,1'b0,4'd2}, // R2
    '{1'b1,1'b1,1'b0,2'b00,8'h00,3'd2,3'b011,1'b0,1'b0,4'd7}, // R7 held mode used
    '{1'b1,1'b0,1'b0,2'b00,8'h01,3'd0,3'b111,1'b0,1'b0,4'd2}, // R2 back to RUN
    '{1'b1,1'b0,1'b0,2'b00,8'h00,3'd1,3'b111,1'b1,1'b0,4'd6}, // R6
    '{1'b0,1'b0,1'b0,2'b00,8'h00,3'd0,3'b111,1'b0,1'b0,4'd5}  // R5 request drops
  };

  task automatic check(input int rq, input logic [2:0] emd, input logic [2:0] een,
                       input logic elp, input logic ewk);
    logic [8:0] act, exp;
    act = {mode, core_en, sys_en, bus_en, lp_req, wake_ctl};
    exp = {emd, een, elp, ewk};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d mode/en/lp/wk actual=%b expected=%b", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(8, 3'd0, 3'b111, 1'b0, 1'b0); // R8 during reset
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk);
    #1 check(8, 3'd0, 3'b111, 1'b0, 1'b0); // R8 after release

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      vlp_sel = VEC[i].vlp; slp_req = VEC[i].req; deep = VEC[i].dp;
      cfg = VEC[i].cf; irq = VEC[i].ir;
      @(posedge clk);
      #1 check(int'(VEC[i].rq), VEC[i].md, VEC[i].en, VEC[i].lp, VEC[i].wk);
    end

    // R8: asynchronous reset from STOP entered out of VLPR
    @(negedge clk); vlp_sel = 1'b1; slp_req = 1'b0; irq = 8'h00;
    @(negedge clk); slp_req = 1'b1; deep = 1'b1; cfg = 2'b00;
    @(posedge clk);
    #1 check(3, 3'd4, 3'b000, 1'b1, 1'b1); // R3
    @(negedge clk); slp_req = 1'b0; vlp_sel = 1'b0;
    #2 rst_ni = 1'b0;
    #1 check(8, 3'd0, 3'b111, 1'b0, 1'b0); // R8 immediate
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk); slp_req = 1'b1; deep = 1'b1; cfg = 2'b10;
    @(posedge clk);
    #1 check(5, 3'd5, 3'b001, 1'b0, 1'b1); // R5 saved run cleared by reset
    @(negedge clk); slp_req = 1'b0; irq = 8'h01;
    @(posedge clk);
    #1 check(8, 3'd0, 3'b111, 1'b0, 1'b0); // R8 returns to RUN
    @(negedge clk); irq = 8'h00;
    finish_run();
  end
endmodule